// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block keeps the coherence state of one cache line in a private cache on a snooping bus. The state is one of four: Invalid (I), Shared (S), Exclusive (E) and Modified (M). On the processor side it accepts read and write requests. For each request it reports a hit, or it starts a bus transaction. A miss or a write to a shared line stalls the processor until that transaction completes. The three transactions are read (BusRd), read-for-ownership (BusRdX) and upgrade (BusUpgr). On the snoop side it watches transactions placed on the bus by other caches. It answers them with a shared indication, a data-supply request and a write-back request, and it moves the line to the state those transactions demand.

The request tracker has three phases: IDLE, ARB (waiting for the bus grant) and XFER (own transaction in flight). Each processor request is classified as follows:
- A read hit in S, E or M, or a write hit in M, leaves the state unchanged.
- A write hit in E moves the line silently from E to M.
- A read miss in I goes I -> E when no other cache holds the line, or I -> S when another cache does.
- A write miss in I goes I -> M using BusRdX.
- A write in S goes S -> M using BusUpgr.

Snooped transactions cause these transitions:
- E -> S or M -> S on a foreign read. The line supplies data, and a write-back is also requested when leaving M.
- S -> I or E -> I on a foreign BusRdX or BusUpgr.
- M -> I on a foreign BusRdX, with data supplied.

Tag matching, data storage, replacement and arbitration are outside the block. Only one processor request is outstanding at a time.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset the line state is Invalid (encoding I=00, S=01, E=10, M=11), and cpu_busy, bus_req and all snoop responses are low.
- R2: A read accepted in Invalid raises bus_req with bus_req_op=01 (read) from the next cycle until the grant is sampled. The line becomes E if bus_shared_in is low in the completion cycle, and S if it is high.
- R3: A write accepted in Invalid requests the bus with bus_req_op=10 (read-for-ownership), and the line becomes M.
- R4: A write accepted in Shared requests the bus with bus_req_op=11 (upgrade), and the line becomes M.
- R5: A write accepted in Exclusive is a hit with no bus request, and the line is M on the next cycle.
- R6: Reads accepted in S, E or M, and writes accepted in M, are hits: cpu_hit is high in the request cycle, there is no bus request, and the state is unchanged.
- R7: A snooped read (snoop_op=01) in E or M asserts snoop_supply and moves the line to S. In M it also asserts snoop_wb.
- R8: A snooped read asserts snoop_shared_out whenever the line is valid. In S it gives no data supply, and the line stays S.
- R9: A snooped read-for-ownership (10) or upgrade (11) invalidates a line in S or E without supplying data. A snooped read-for-ownership in M supplies data and invalidates. A snooped upgrade in M changes nothing.
- R10: Snooped transactions on an Invalid line produce no response and leave it Invalid.
- R11: If a pending upgrade loses the line to a snooped invalidation before its grant, the request is reissued as read-for-ownership (10). The line still ends in M.
- R12: cpu_busy is high while a snoop is presented or a bus transaction is open. A request presented while busy is not accepted and changes no state.
- R13: cpu_done pulses in the cycle bus_done is sampled. The new state appears on the next cycle, together with cpu_busy going low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_busy | output | 1 | Request cannot be accepted this cycle |
| cpu_hit | output | 1 | Accepted request completed without bus traffic |
| cpu_miss | output | 1 | Accepted request needs a bus transaction |
| cpu_done | output | 1 | Own bus transaction completes this cycle |
| bus_req | output | 1 | Request for the bus |
| bus_req_op | output | 2 | Transaction type: 01 read, 10 read-for-ownership, 11 upgrade |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_done | input | 1 | Own transaction finishes |
| bus_shared_in | input | 1 | Another cache holds the line (valid with bus_done) |
| snoop_valid | input | 1 | Foreign transaction on the bus |
| snoop_op | input | 2 | Foreign transaction type, same encoding as bus_req_op |
| snoop_shared_out | output | 1 | This cache holds the line valid |
| snoop_supply | output | 1 | This cache must supply the data |
| snoop_wb | output | 1 | Dirty data must be written back to memory |
| line_state | output | 2 | Current state: 00 I, 01 S, 10 E, 11 M |

## Verification
The following outputs are combinational and valid in the same cycle as their stimulus: cpu_hit, cpu_miss, cpu_busy, cpu_done and the three snoop responses. The bench samples them 2 ns after driving the inputs, before the next rising edge. line_state, bus_req and bus_req_op are registered, so the bench reads them one cycle after the edge that samples the stimulus. For a bus transaction, that edge is the one on which bus_done is taken. Each directed task drives its inputs just after a rising edge, checks the combinational responses in that cycle, steps one edge, and then checks the registered state.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_EXC = 2'b10,
        LS_MOD = 2'b11
    } line_state_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_RD   = 2'b01,
        OP_RDX  = 2'b10,
        OP_UPG  = 2'b11
    } bus_op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_ARB  = 2'b01,
        PH_XFER = 2'b10
    } req_phase_e;

endpackage

// File: rtl/mesi_req_tracker.sv
module mesi_req_tracker
    import mesi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        snoop_active,
    input  line_state_e cur_state,
    input  logic        gnt,
    input  logic        done,
    input  logic        shared_in,
    output logic        busy,
    output logic        hit,
    output logic        miss,
    output logic        hit_write_exc,
    output logic        in_xfer,
    output logic        bus_req,
    output bus_op_e     bus_op,
    output logic        commit,
    output line_state_e commit_state
);

    req_phase_e phase_q;
    bus_op_e    pend_op_q;
    bus_op_e    want_op;
    bus_op_e    eff_op;
    logic       accept;

    // Classification of a request against the present line state
    always_comb begin
        want_op = OP_NONE;
        unique case (cur_state)
            LS_INV:  want_op = req_write ? OP_RDX : OP_RD;
            LS_SHR:  want_op = req_write ? OP_UPG : OP_NONE;
            LS_EXC:  want_op = OP_NONE;
            LS_MOD:  want_op = OP_NONE;
            default: want_op = OP_NONE;
        endcase
    end

    // An upgrade whose line vanished must refetch the data
    assign eff_op = (pend_op_q == OP_UPG && cur_state == LS_INV) ? OP_RDX : pend_op_q;

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            pend_op_q <= OP_NONE;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (accept && want_op != OP_NONE) begin
                        phase_q   <= PH_ARB;
                        pend_op_q <= want_op;
                    end
                end
                PH_ARB: begin
                    pend_op_q <= eff_op;
                    if (gnt) phase_q <= PH_XFER;
                end
                PH_XFER: begin
                    if (done) begin
                        phase_q   <= PH_IDLE;
                        pend_op_q <= OP_NONE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy          = (phase_q != PH_IDLE) || snoop_active;
        accept        = req_valid && !busy;
        hit           = accept && (want_op == OP_NONE);
        miss          = accept && (want_op != OP_NONE);
        hit_write_exc = hit && req_write && (cur_state == LS_EXC);
        in_xfer       = (phase_q == PH_XFER);
        bus_req       = (phase_q == PH_ARB);
        bus_op        = OP_NONE;
        commit        = 1'b0;
        commit_state  = LS_INV;
        unique case (phase_q)
            PH_IDLE: bus_op = OP_NONE;
            PH_ARB:  bus_op = eff_op;
            PH_XFER: begin
                bus_op = pend_op_q;
                commit = done;
                if (pend_op_q == OP_RD)
                    commit_state = shared_in ? LS_SHR : LS_EXC;
                else
                    commit_state = LS_MOD;
            end
            default: bus_op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/mesi_snoop_decode.sv
module mesi_snoop_decode
    import mesi_pkg::*;
(
    input  logic        snoop_valid,
    input  logic        in_xfer,
    input  bus_op_e     snoop_op,
    input  line_state_e cur_state,
    output logic        shared_out,
    output logic        supply,
    output logic        wb,
    output logic        apply,
    output line_state_e next_state
);

    logic active;
    assign active = snoop_valid && !in_xfer;

    always_comb begin
        shared_out = 1'b0;
        supply     = 1'b0;
        wb         = 1'b0;
        apply      = 1'b0;
        next_state = cur_state;
        if (active) begin
            unique case (cur_state)
                LS_INV: begin
                    next_state = LS_INV;
                end
                LS_SHR: begin
                    if (snoop_op == OP_RD) begin
                        shared_out = 1'b1;
                    end else if (snoop_op != OP_NONE) begin
                        apply      = 1'b1;
                        next_state = LS_INV;
                    end
                end
                LS_EXC: begin
                    if (snoop_op == OP_RD) begin
                        shared_out = 1'b1;
                        supply     = 1'b1;
                        apply      = 1'b1;
                        next_state = LS_SHR;
                    end else if (snoop_op != OP_NONE) begin
                        apply      = 1'b1;
                        next_state = LS_INV;
                    end
                end
                LS_MOD: begin
                    if (snoop_op == OP_RD) begin
                        shared_out = 1'b1;
                        supply     = 1'b1;
                        wb         = 1'b1;
                        apply      = 1'b1;
                        next_state = LS_SHR;
                    end else if (snoop_op == OP_RDX) begin
                        supply     = 1'b1;
                        apply      = 1'b1;
                        next_state = LS_INV;
                    end
                end
                default: next_state = LS_INV;
            endcase
        end
    end

endmodule

// File: rtl/mesi_state_reg.sv
module mesi_state_reg
    import mesi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        commit,
    input  line_state_e commit_state,
    input  logic        snoop_apply,
    input  line_state_e snoop_next,
    input  logic        silent_upgrade,
    output line_state_e state_q
);

    line_state_e state_d;

    // Own completion first, then foreign snoop, then a silent E->M write
    always_comb begin
        state_d = state_q;
        if (commit)
            state_d = commit_state;
        else if (snoop_apply)
            state_d = snoop_next;
        else if (silent_upgrade)
            state_d = LS_MOD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LS_INV;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_req_valid,
    input  logic       cpu_req_write,
    output logic       cpu_busy,
    output logic       cpu_hit,
    output logic       cpu_miss,
    output logic       cpu_done,
    output logic       bus_req,
    output logic [1:0] bus_req_op,
    input  logic       bus_gnt,
    input  logic       bus_done,
    input  logic       bus_shared_in,
    input  logic       snoop_valid,
    input  logic [1:0] snoop_op,
    output logic       snoop_shared_out,
    output logic       snoop_supply,
    output logic       snoop_wb,
    output logic [1:0] line_state
);

    line_state_e state_q;
    line_state_e commit_state;
    line_state_e snoop_next;
    bus_op_e     snoop_op_e;
    bus_op_e     own_op;
    logic        in_xfer;
    logic        commit;
    logic        snoop_apply;
    logic        silent_upgrade;

    assign snoop_op_e = bus_op_e'(snoop_op);

    mesi_req_tracker u_req (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (cpu_req_valid),
        .req_write     (cpu_req_write),
        .snoop_active  (snoop_valid),
        .cur_state     (state_q),
        .gnt           (bus_gnt),
        .done          (bus_done),
        .shared_in     (bus_shared_in),
        .busy          (cpu_busy),
        .hit           (cpu_hit),
        .miss          (cpu_miss),
        .hit_write_exc (silent_upgrade),
        .in_xfer       (in_xfer),
        .bus_req       (bus_req),
        .bus_op        (own_op),
        .commit        (commit),
        .commit_state  (commit_state)
    );

    mesi_snoop_decode u_snoop (
        .snoop_valid (snoop_valid),
        .in_xfer     (in_xfer),
        .snoop_op    (snoop_op_e),
        .cur_state   (state_q),
        .shared_out  (snoop_shared_out),
        .supply      (snoop_supply),
        .wb          (snoop_wb),
        .apply       (snoop_apply),
        .next_state  (snoop_next)
    );

    mesi_state_reg u_state (
        .clk            (clk),
        .rst_n          (rst_n),
        .commit         (commit),
        .commit_state   (commit_state),
        .snoop_apply    (snoop_apply),
        .snoop_next     (snoop_next),
        .silent_upgrade (silent_upgrade),
        .state_q        (state_q)
    );

    assign cpu_done   = commit;
    assign bus_req_op = own_op;
    assign line_state = state_q;

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_req_valid,
    input logic       cpu_req_write,
    input logic       cpu_busy,
    input logic       cpu_hit,
    input logic       cpu_miss,
    input logic       cpu_done,
    input logic       bus_req,
    input logic [1:0] bus_req_op,
    input logic       bus_gnt,
    input logic       bus_done,
    input logic       bus_shared_in,
    input logic       snoop_valid,
    input logic [1:0] snoop_op,
    input logic       snoop_shared_out,
    input logic       snoop_supply,
    input logic       snoop_wb,
    input logic [1:0] line_state
);

    // R2: request held until granted
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req);

    // R5: silent upgrade from Exclusive
    a_r5_silent_upgrade: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_valid && cpu_req_write && !cpu_busy && line_state == 2'b10
        |=> line_state == 2'b11 && !bus_req);

    // R7: supplying on a foreign read leaves the line Shared
    a_r7_supply_downgrade: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_supply && snoop_op == 2'b01 |=> line_state == 2'b01);

    // R9: supplying on a foreign read-for-ownership invalidates
    a_r9_supply_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_supply && snoop_op == 2'b10 |=> line_state == 2'b00);

    // R10: no response from an Invalid line
    a_r10_invalid_silent: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_valid && line_state == 2'b00 |-> !snoop_supply && !snoop_shared_out && !snoop_wb);

    // R12: a bus request always comes with a stalled processor
    a_r12_busy_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> cpu_busy);

    // R13: ownership transactions commit to Modified
    a_r13_commit_mod: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done && bus_req_op != 2'b01 |=> line_state == 2'b11);

    // R2 / R13: read completion follows the shared indication
    a_r13_commit_read: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done && bus_req_op == 2'b01 |=> line_state == ($past(bus_shared_in) ? 2'b01 : 2'b10));

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk u_chk (.*);

// File: tb/tb_mesi_line_ctrl.sv
module tb_mesi_line_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cpu_req_valid, cpu_req_write;
    logic       cpu_busy, cpu_hit, cpu_miss, cpu_done;
    logic       bus_req;
    logic [1:0] bus_req_op;
    logic       bus_gnt, bus_done, bus_shared_in;
    logic       snoop_valid;
    logic [1:0] snoop_op;
    logic       snoop_shared_out, snoop_supply, snoop_wb;
    logic [1:0] line_state;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    localparam logic [1:0] I = 2'b00, S = 2'b01, E = 2'b10, M = 2'b11;
    localparam logic [1:0] RD = 2'b01, RDX = 2'b10, UPG = 2'b11;

    always #10 clk = ~clk;

    mesi_line_ctrl dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_hit(logic wr, logic [1:0] exp_state, string req);
        cpu_req_valid = 1'b1; cpu_req_write = wr;
        #2;
        chk(req, cpu_hit, 1, "hit");
        chk(req, cpu_miss, 0, "miss");
        tick();
        cpu_req_valid = 1'b0;
        chk(req, bus_req, 0, "bus_req after hit");
        chk(req, line_state, exp_state, "state after hit");
    endtask

    task automatic do_miss(logic wr, logic [1:0] exp_op, logic shr, int waits,
                           logic [1:0] exp_state, string req);
        cpu_req_valid = 1'b1; cpu_req_write = wr;
        #2;
        chk(req, cpu_miss, 1, "miss");
        chk(req, cpu_hit, 0, "hit");
        tick();
        cpu_req_valid = 1'b0;
        chk(req, cpu_busy, 1, "busy");
        chk(req, bus_req, 1, "bus_req");
        chk(req, bus_req_op, exp_op, "bus_req_op");
        for (int k = 0; k < waits; k++) begin
            tick();
            chk(req, bus_req, 1, "bus_req held");
        end
        bus_gnt = 1'b1;
        tick();
        bus_gnt = 1'b0;
        chk(req, bus_req, 0, "bus_req after grant");
        chk(req, cpu_busy, 1, "busy in transfer");
        tick();
        bus_done = 1'b1; bus_shared_in = shr;
        #2;
        chk("R13", cpu_done, 1, "done pulse");
        tick();
        bus_done = 1'b0; bus_shared_in = 1'b0;
        chk(req, line_state, exp_state, "state after completion");
        chk("R13", cpu_busy, 0, "busy after completion");
    endtask

    task automatic do_snoop(logic [1:0] op, logic e_shr, logic e_sup, logic e_wb,
                            logic [1:0] exp_state, string req);
        snoop_valid = 1'b1; snoop_op = op;
        #2;
        chk(req, snoop_shared_out, e_shr, "shared_out");
        chk(req, snoop_supply, e_sup, "supply");
        chk(req, snoop_wb, e_wb, "wb");
        chk("R12", cpu_busy, 1, "busy during snoop");
        tick();
        snoop_valid = 1'b0; snoop_op = 2'b00;
        chk(req, line_state, exp_state, "state after snoop");
    endtask

    task automatic t_upgrade_race();
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1;
        #2;
        chk("R11", cpu_miss, 1, "miss");
        tick();
        cpu_req_valid = 1'b0;
        chk("R11", bus_req_op, UPG, "initial op upgrade");
        snoop_valid = 1'b1; snoop_op = RDX;
        tick();
        snoop_valid = 1'b0; snoop_op = 2'b00;
        chk("R11", line_state, I, "lost line");
        chk("R11", bus_req, 1, "still requesting");
        chk("R11", bus_req_op, RDX, "reissued op");
        bus_gnt = 1'b1;
        tick();
        bus_gnt = 1'b0;
        chk("R11", bus_req_op, RDX, "op in transfer");
        bus_done = 1'b1;
        tick();
        bus_done = 1'b0;
        chk("R11", line_state, M, "final state");
    endtask

    task automatic t_collision();
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1;
        snoop_valid = 1'b1; snoop_op = RD;
        #2;
        chk("R12", cpu_busy, 1, "busy with snoop");
        chk("R12", cpu_hit, 0, "no hit while busy");
        chk("R12", cpu_miss, 0, "no miss while busy");
        tick();
        cpu_req_valid = 1'b0; snoop_valid = 1'b0; snoop_op = 2'b00;
        chk("R12", line_state, S, "write not applied");
        chk("R12", bus_req, 0, "no bus request");
    endtask

    initial begin
        #(20 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        cpu_req_valid = 1'b0; cpu_req_write = 1'b0;
        bus_gnt = 1'b0; bus_done = 1'b0; bus_shared_in = 1'b0;
        snoop_valid = 1'b0; snoop_op = 2'b00;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1", line_state, I, "reset state");
        chk("R1", cpu_busy, 0, "reset busy");
        chk("R1", bus_req, 0, "reset bus_req");
        chk("R1", {snoop_shared_out, snoop_supply, snoop_wb}, 0, "reset snoop outputs");

        do_snoop(RD, 0, 0, 0, I, "R10");
        do_snoop(RDX, 0, 0, 0, I, "R10");
        do_miss(1'b0, RD, 1'b0, 2, E, "R2");
        do_snoop(RD, 1, 1, 0, S, "R7");
        do_snoop(RD, 1, 0, 0, S, "R8");
        do_hit(1'b0, S, "R6");
        do_miss(1'b1, UPG, 1'b0, 1, M, "R4");
        do_hit(1'b0, M, "R6");
        do_hit(1'b1, M, "R6");
        do_snoop(UPG, 0, 0, 0, M, "R9");
        do_snoop(RD, 1, 1, 1, S, "R7");
        do_snoop(UPG, 0, 0, 0, I, "R9");
        do_miss(1'b1, RDX, 1'b0, 0, M, "R3");
        do_snoop(RDX, 0, 1, 0, I, "R9");
        do_miss(1'b0, RD, 1'b1, 3, S, "R2");
        do_snoop(RDX, 0, 0, 0, I, "R9");
        do_miss(1'b0, RD, 1'b0, 0, E, "R2");
        do_hit(1'b0, E, "R6");
        do_snoop(RDX, 0, 0, 0, I, "R9");
        do_miss(1'b0, RD, 1'b0, 1, E, "R2");
        do_hit(1'b1, M, "R5");
        do_snoop(RD, 1, 1, 1, S, "R7");
        t_upgrade_race();
        do_snoop(RDX, 0, 1, 0, I, "R9");
        do_miss(1'b0, RD, 1'b0, 0, E, "R2");
        t_collision();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule